// File: doc/BRIEF.md
# Floating-Point Status and Trap Control Register

This block holds the 16-bit status and control word of a floating-point coprocessor and turns the raw exception indications of the arithmetic datapath into a trap-type code, sticky flags and a trap request. Each arithmetic instruction that completes pulses `done_i` and presents its raw indications in the same cycle. The block then chooses one code, updates the flags and raises `trap_o` in that cycle, according to the two trap enable bits. It also watches the current instruction word and flags the two reserved encodings as illegal.

The load-status instruction writes the whole word through `ld_i`/`ld_data_i`, and the store-status instruction reads it from `status_o`. Neither of them pulses `done_i`, so neither disturbs the trap-type field. The rounding-mode and software fields are plain storage that the datapath and software read back. When an underflow occurs while its trap is disabled, `zero_res_o` tells the datapath to deliver positive zero.

Top module: `fp_status_unit`

## Requirements
- R1: After reset `status_o` reads 16'h0000, and `trap_o` and `zero_res_o` are low while `done_i` is low.
- R2: A cycle with `ld_i` high writes `ld_data_i` into all 16 bits, and it wins over a `done_i` in the same cycle. Bits 15:9 (software), bits 8:7 (rounding mode) and the enables at bit 3 (underflow) and bit 5 (inexact) change only through a load.
- R3: On completion bits 2:0 take a code chosen by priority: illegal 100, then invalid 101, then divide-by-zero 011, then overflow 010, then underflow 001. Inexact alone gives 110.
- R4: A completion with no exception writes 000 into bits 2:0.
- R5: `dz_i` with `dvd_zero_i` low reports divide-by-zero 011. `dz_i` with `dvd_zero_i` high reports invalid 101 instead.
- R6: `illegal_o` is high exactly when instruction bits 7:0 equal 8'b10111110 and bits 13:10 equal 4'b0011 or 4'b1001. A completion with that word reports 100.
- R7: The underflow flag (bit 4) is set by every completion with `unf_i` high, whatever bit 3 holds. Only reset or a load clears it.
- R8: The inexact flag (bit 6) is set only when inexact is the sole exception of the completion. Otherwise it keeps its value. Only reset or a load clears it.
- R9: `trap_o` pulses in the completion cycle for illegal, invalid, divide-by-zero and overflow. For underflow it pulses only when bit 3 is 1, and for inexact alone only when bit 5 is 1. It is never high without `done_i`.
- R10: `zero_res_o` is high in a completion cycle exactly when `unf_i` is high and bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_i | input | 1 | Arithmetic instruction completes this cycle |
| insn_i | input | INSN_W | Current instruction word |
| unf_i | input | 1 | Raw underflow indication |
| ovf_i | input | 1 | Raw overflow indication |
| dz_i | input | 1 | Divisor is zero |
| dvd_zero_i | input | 1 | Dividend is zero (qualifies dz_i) |
| inv_i | input | 1 | Reserved operand seen |
| inx_i | input | 1 | Result had to be rounded |
| ld_i | input | 1 | Load-status write strobe |
| ld_data_i | input | 16 | Value written by a load |
| status_o | output | 16 | Current register contents |
| illegal_o | output | 1 | Instruction word is an illegal form |
| trap_o | output | 1 | Trap request, one cycle |
| zero_res_o | output | 1 | Deliver positive zero for a disabled underflow |

## Verification
The assertions rely on the raw exception inputs being meaningful only while `done_i` is high. They also rely on the datapath raising `dvd_zero_i` only alongside a divide. The stimulus drives every raw input together with the done pulse, and it returns the inputs to zero between cases. Every case is preceded by a load that sets the enables and clears both flags. Each of the 64 exception combinations is crossed with both enable settings and with a legal or illegal word, so the priority and suppression rules are covered exhaustively.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

   localparam int CSR_W   = 16;
   localparam int TT_LSB  = 0;
   localparam int TT_W    = 3;
   localparam int UEN_BIT = 3;
   localparam int UF_BIT  = 4;
   localparam int IEN_BIT = 5;
   localparam int IF_BIT  = 6;
   localparam int RM_LSB  = 7;
   localparam int RM_W    = 2;
   localparam int SW_LSB  = RM_LSB + RM_W;
   localparam int SW_W    = CSR_W - SW_LSB;

   typedef enum logic [TT_W-1:0] {
      TT_NONE = 3'b000,
      TT_UNF  = 3'b001,
      TT_OVF  = 3'b010,
      TT_DZ   = 3'b011,
      TT_ILL  = 3'b100,
      TT_INV  = 3'b101,
      TT_INX  = 3'b110,
      TT_RSV  = 3'b111
   } tt_e;

   typedef struct packed {
      logic ill;
      logic inv;
      logic dz;
      logic dvd_zero;
      logic ovf;
      logic unf;
      logic inx;
   } exc_s;

endpackage

// File: rtl/fpst_ill_dec.sv
module fpst_ill_dec #(
   parameter int         OPC_W   = 8,
   parameter int         FMT_W   = 4,
   parameter int         FMT_LSB = 10,
   parameter logic [7:0] OPC     = 8'b1011_1110,
   parameter logic [3:0] FMT_A   = 4'b0011,
   parameter logic [3:0] FMT_B   = 4'b1001,
   parameter bit         ENABLE  = 1'b1,
   localparam int        SPAN_W  = FMT_LSB + FMT_W
) (
   input  logic [SPAN_W-1:0] word_i,
   output logic              hit_o
);

   generate
      if (ENABLE) begin : g_dec
         logic opc_hit;
         logic fmt_hit;
         logic unused_mid;
         assign opc_hit    = (word_i[OPC_W-1:0] == OPC[OPC_W-1:0]);
         assign fmt_hit    = (word_i[SPAN_W-1:FMT_LSB] == FMT_A[FMT_W-1:0]) ||
                             (word_i[SPAN_W-1:FMT_LSB] == FMT_B[FMT_W-1:0]);
         assign unused_mid = ^word_i[FMT_LSB-1:OPC_W];
         assign hit_o      = opc_hit && fmt_hit;
      end else begin : g_off
         logic unused_word;
         assign unused_word = ^word_i;
         assign hit_o       = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/fpst_exc_prio.sv
module fpst_exc_prio
   import fpst_pkg::*;
(
   input  exc_s raw_i,
   input  logic uen_i,
   input  logic ien_i,
   output tt_e  code_o,
   output logic set_uf_o,
   output logic set_if_o,
   output logic trap_o,
   output logic zero_res_o
);

   logic dz_eff;
   logic inv_eff;
   logic other;

   assign dz_eff  = raw_i.dz & ~raw_i.dvd_zero;
   assign inv_eff = raw_i.inv | (raw_i.dz & raw_i.dvd_zero);
   assign other   = raw_i.ill | inv_eff | dz_eff | raw_i.ovf | raw_i.unf;

   always_comb begin
      if (raw_i.ill)       code_o = TT_ILL;
      else if (inv_eff)    code_o = TT_INV;
      else if (dz_eff)     code_o = TT_DZ;
      else if (raw_i.ovf)  code_o = TT_OVF;
      else if (raw_i.unf)  code_o = TT_UNF;
      else if (raw_i.inx)  code_o = TT_INX;
      else                 code_o = TT_NONE;
   end

   assign set_uf_o   = raw_i.unf;
   assign set_if_o   = raw_i.inx & ~other;
   assign trap_o     = raw_i.ill | inv_eff | dz_eff | raw_i.ovf |
                       (raw_i.unf & uen_i) | (set_if_o & ien_i);
   assign zero_res_o = raw_i.unf & ~uen_i;

endmodule

// File: rtl/fpst_csr.sv
module fpst_csr
   import fpst_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_i,
   input  logic [CSR_W-1:0] ld_data_i,
   input  logic             upd_i,
   input  tt_e              code_i,
   input  logic             set_uf_i,
   input  logic             set_if_i,
   output logic [CSR_W-1:0] csr_o
);

   logic [CSR_W-1:0] csr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csr_q <= '0;
      end else if (ld_i) begin
         csr_q <= ld_data_i;
      end else if (upd_i) begin
         csr_q[TT_LSB +: TT_W] <= code_i;
         if (set_uf_i) csr_q[UF_BIT] <= 1'b1;
         if (set_if_i) csr_q[IF_BIT] <= 1'b1;
      end
   end

   assign csr_o = csr_q;

endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
   import fpst_pkg::*;
#(
   parameter int INSN_W     = 24,
   parameter bit DECODE_ILL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [INSN_W-1:0] insn_i,
   input  logic              unf_i,
   input  logic              ovf_i,
   input  logic              dz_i,
   input  logic              dvd_zero_i,
   input  logic              inv_i,
   input  logic              inx_i,
   input  logic              ld_i,
   input  logic [CSR_W-1:0]  ld_data_i,
   output logic [CSR_W-1:0]  status_o,
   output logic              illegal_o,
   output logic              trap_o,
   output logic              zero_res_o
);

   localparam int DEC_W = 14;

   generate
      if (INSN_W < DEC_W) begin : g_bad_w
         $error("fp_status_unit: INSN_W must cover bits 13:0");
      end
      if (SW_LSB + SW_W != CSR_W) begin : g_bad_map
         $error("fp_status_unit: field map does not fill the register");
      end
   endgenerate

   logic upd;
   exc_s raw;
   tt_e  code;
   logic set_uf, set_if, trap_raw, zero_raw;

   generate
      if (INSN_W > DEC_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^insn_i[INSN_W-1:DEC_W];
      end
   endgenerate

   fpst_ill_dec #(.ENABLE(DECODE_ILL)) u_dec (
      .word_i (insn_i[DEC_W-1:0]),
      .hit_o  (illegal_o)
   );

   assign upd = done_i & ~ld_i;

   always_comb begin
      raw          = '0;
      raw.ill      = illegal_o;
      raw.inv      = inv_i;
      raw.dz       = dz_i;
      raw.dvd_zero = dvd_zero_i;
      raw.ovf      = ovf_i;
      raw.unf      = unf_i;
      raw.inx      = inx_i;
   end

   fpst_exc_prio u_prio (
      .raw_i      (raw),
      .uen_i      (status_o[UEN_BIT]),
      .ien_i      (status_o[IEN_BIT]),
      .code_o     (code),
      .set_uf_o   (set_uf),
      .set_if_o   (set_if),
      .trap_o     (trap_raw),
      .zero_res_o (zero_raw)
   );

   fpst_csr u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_i      (ld_i),
      .ld_data_i (ld_data_i),
      .upd_i     (upd),
      .code_i    (code),
      .set_uf_i  (set_uf),
      .set_if_i  (set_if),
      .csr_o     (status_o)
   );

   assign trap_o     = upd & trap_raw;
   assign zero_res_o = upd & zero_raw;

endmodule

// File: rtl/fpst_checker.sv
module fpst_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        done_i,
   input logic        ld_i,
   input logic        unf_i,
   input logic        ovf_i,
   input logic        dz_i,
   input logic        dvd_zero_i,
   input logic        inv_i,
   input logic        inx_i,
   input logic [15:0] status_o,
   input logic        illegal_o,
   input logic        trap_o,
   input logic        zero_res_o
);

   logic any_exc;
   assign any_exc = unf_i | ovf_i | dz_i | inv_i | inx_i | illegal_o;

   assert_trap_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> done_i);

   assert_unf_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !ld_i && unf_i && status_o[3]) |-> trap_o);

   assert_clean_clears_tt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !ld_i && !any_exc) |=> (status_o[2:0] == 3'b000));

   assert_uf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[4] && !ld_i) |=> status_o[4]);

   assert_if_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[6] && !ld_i) |=> status_o[6]);

   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_i |=> ($stable(status_o[15:7]) && $stable(status_o[3]) && $stable(status_o[5])));

   assert_zero_res_R10: assert property (@(posedge clk) disable iff (!rst_n)
      zero_res_o |-> (done_i && unf_i && !status_o[3]));

   assert_dz_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !ld_i && dz_i && !dvd_zero_i && !inv_i && !illegal_o)
      |=> (status_o[2:0] == 3'b011));

   assert_ill_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !ld_i && illegal_o) |=> (status_o[2:0] == 3'b100));

endmodule

bind fp_status_unit fpst_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .done_i     (done_i),
   .ld_i       (ld_i),
   .unf_i      (unf_i),
   .ovf_i      (ovf_i),
   .dz_i       (dz_i),
   .dvd_zero_i (dvd_zero_i),
   .inv_i      (inv_i),
   .inx_i      (inx_i),
   .status_o   (status_o),
   .illegal_o  (illegal_o),
   .trap_o     (trap_o),
   .zero_res_o (zero_res_o)
);

// File: tb/sim_fp_status_unit.sv
module sim_fp_status_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        done_i = 1'b0;
   logic [23:0] insn_i = '0;
   logic        unf_i = 1'b0, ovf_i = 1'b0, dz_i = 1'b0, dvd_zero_i = 1'b0;
   logic        inv_i = 1'b0, inx_i = 1'b0, ld_i = 1'b0;
   logic [15:0] ld_data_i = '0;
   logic [15:0] status_o;
   logic        illegal_o, trap_o, zero_res_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   fp_status_unit u0 (
      .clk(clk), .rst_n(rst_n), .done_i(done_i), .insn_i(insn_i),
      .unf_i(unf_i), .ovf_i(ovf_i), .dz_i(dz_i), .dvd_zero_i(dvd_zero_i),
      .inv_i(inv_i), .inx_i(inx_i), .ld_i(ld_i), .ld_data_i(ld_data_i),
      .status_o(status_o), .illegal_o(illegal_o), .trap_o(trap_o),
      .zero_res_o(zero_res_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      done_i = 0; unf_i = 0; ovf_i = 0; dz_i = 0; dvd_zero_i = 0;
      inv_i = 0; inx_i = 0; ld_i = 0; insn_i = 24'h0000BE;
   endtask

   task automatic load(input logic [15:0] v);
      @(negedge clk); idle(); ld_i = 1; ld_data_i = v;
      @(negedge clk); ld_i = 0;
   endtask

   // one completion, started at a negedge, checked mid-cycle and after the edge
   task automatic run_case(input int e, input bit uen, input bit ien, input bit ill);
      logic [15:0] pre, expv;
      logic [2:0]  code;
      bit u, o, d, z, v, x, dze, inve, other, trp, ifs;
      u = e[0]; o = e[1]; d = e[2]; z = e[3]; v = e[4]; x = e[5];
      pre = {7'h2A, 2'b10, 1'b0, ien, 1'b0, uen, 3'b000};
      load(pre);
      dze   = d && !z;
      inve  = v || (d && z);
      other = ill || inve || dze || o || u;
      if (ill)       code = 3'b100;
      else if (inve) code = 3'b101;
      else if (dze)  code = 3'b011;
      else if (o)    code = 3'b010;
      else if (u)    code = 3'b001;
      else if (x)    code = 3'b110;
      else           code = 3'b000;
      ifs  = x && !other;
      trp  = ill || inve || dze || o || (u && uen) || (ifs && ien);
      expv = {7'h2A, 2'b10, ifs, ien, u, uen, code};
      unf_i = u; ovf_i = o; dz_i = d; dvd_zero_i = z; inv_i = v; inx_i = x;
      insn_i = ill ? 24'h000CBE : 24'h0000BE;
      done_i = 1;
      #1;
      chk("R9 trap", {15'd0, trap_o}, {15'd0, trp});
      chk("R10 zero result", {15'd0, zero_res_o}, {15'd0, u && !uen});
      @(posedge clk); #1;
      chk("R3/R5/R6/R7/R8 status", status_o, expv);
      @(negedge clk); idle();
   endtask

   initial begin
      #(8 * 200000);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset status", status_o, 16'h0000);
      rst_n = 1;
      @(negedge clk); #1;
      chk("R1 reset status held", status_o, 16'h0000);
      chk("R1 outputs idle", {14'd0, trap_o, zero_res_o}, 16'h0000);

      // R6 decode sweep: bits 13:8 with the matching opcode
      for (int f = 0; f < 64; f++) begin
         insn_i = {10'h3FF, f[5:0], 8'hBE};
         #1;
         chk("R6 format sweep", {15'd0, illegal_o},
             {15'd0, ((f >> 2) == 3) || ((f >> 2) == 9)});
      end
      // R6 decode sweep: bits 7:0 with a matching format
      for (int op = 0; op < 256; op++) begin
         insn_i = {10'h000, 4'b1001, 2'b01, op[7:0]};
         #1;
         chk("R6 opcode sweep", {15'd0, illegal_o}, {15'd0, op == 8'hBE});
      end
      idle();

      // exhaustive exception sweep (R3, R5, R7, R8, R9, R10)
      for (int e = 0; e < 64; e++)
         for (int en = 0; en < 4; en++)
            for (int il = 0; il < 2; il++)
               run_case(e, en[0], en[1], il[0]);

      // R7 stickiness and R4 clean completion
      load(16'h0000);
      unf_i = 1; done_i = 1; #1;
      chk("R10 zero result, enable off", {15'd0, zero_res_o}, 16'd1);
      chk("R9 no underflow trap, enable off", {15'd0, trap_o}, 16'd0);
      @(negedge clk); idle(); done_i = 1;
      @(negedge clk); idle(); #1;
      chk("R4/R7 clean completion keeps flag", status_o, 16'h0010);
      inx_i = 1; done_i = 1;
      @(negedge clk); idle(); #1;
      chk("R8 inexact alone", status_o, 16'h0056);
      ovf_i = 1; done_i = 1;
      @(negedge clk); idle(); #1;
      chk("R8 flag kept under overflow", status_o, 16'h0052);
      load(16'h0000); #1;
      chk("R7/R8 load clears flags", status_o, 16'h0000);

      // R2 load beats completion, control fields survive completions
      @(negedge clk); ld_i = 1; ld_data_i = 16'hA5A0; done_i = 1; ovf_i = 1; #1;
      chk("R2 no trap during load", {15'd0, trap_o}, 16'd0);
      @(negedge clk); idle(); #1;
      chk("R2 load wins", status_o, 16'hA5A0);
      ovf_i = 1; done_i = 1;
      @(negedge clk); idle(); #1;
      chk("R2 fields kept", status_o, 16'hA5A2);
      load(16'hFFFF); #1;
      chk("R2 full write", status_o, 16'hFFFF);
      done_i = 1;
      @(negedge clk); idle(); #1;
      chk("R4 clean completion", status_o, 16'hFFF8);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule